// File: doc/BRIEF.md
# Software-Managed Window Buffer Mover

This block controls a small on-chip buffer (1 KB by default) that holds a copy of a window of external memory. A host reaches both the buffer and three control registers through a Wishbone slave port. The host reads and writes the buffer directly. When it wants the buffer to match external memory, it starts a refresh, which reads the whole window into the buffer. When it wants external memory to match the buffer, it starts a flush, which writes the whole buffer out. The window always begins at a base address that the host programs.

All external traffic leaves through a burst master port. Each burst is a fixed number of words. A request is held until the memory side acknowledges it, and each data word carries its own valid strobe. The block never checks coherency by itself. Software starts each transfer, then polls status flags until it is done.

Top module: `cache_block_mover`

## Requirements
- R1: After reset the status register reads 0, the base register reads 0, and the memory port drives no request and no write-data valid.
- R2: Wishbone word address 0 holds the base (a word address in external memory). Only the low EXT_AW bits are kept. Address 1 is control, which always reads 0. Address 2 is status. A buffer access uses an address whose top bit (bit BUF_AW) is 1, and a register access uses an address whose top bit is 0. Each request gets exactly one ack, one cycle after it is presented. The ack lasts one cycle.
- R3: A Wishbone access with address top bit 1 reads or writes buffer word adr[BUF_AW-1:0].
- R4: Writing control bit 1 (flush) while idle copies buffer word i to external address base+i for every word. Addresses wrap modulo 2^EXT_AW. The copy is done as write bursts of BURST_LEN words, at base, base+BURST_LEN and so on in that order. Each request and its address are held stable until acknowledged. No other external word changes.
- R5: Writing control bit 0 (refresh) while idle copies external words base+i into buffer word i. The copy is done as read bursts in the same address order. Read words are taken only on cycles where the read valid is high.
- R6: Status bit 2 is busy and status bit 1 is flushed. An accepted flush clears flushed and sets busy from the next cycle. Flushed becomes 1 on the same cycle that busy returns to 0, and stays 0 while busy.
- R7: Status bit 0 is refreshed. It is cleared when a refresh is accepted and becomes 1 when the refresh completes, in the same way as R6.
- R8: When both control bits are written together, the flush runs first and the refresh follows. Busy stays high across both transfers. At the end, external memory and the buffer both hold the old buffer contents, and both done flags are set.
- R9: A control write made while busy is ignored. It issues no extra bursts and changes no flag.
- R10: A host write to the buffer made while busy is dropped. The buffer word keeps its old value, and a running flush writes the old value out.
- R11: Write-data valid is only ever high inside an acknowledged write burst. It never coincides with a request, and it is never high for more than BURST_LEN words per burst. While idle, no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Wishbone cycle |
| wb_stb_i | input | 1 | Wishbone strobe |
| wb_we_i | input | 1 | Wishbone write enable |
| wb_adr_i | input | BUF_AW+1 | Word address: top bit selects the buffer, otherwise the register index |
| wb_dat_i | input | DATA_W | Write data |
| wb_dat_o | output | DATA_W | Read data, valid with ack |
| wb_ack_o | output | 1 | Acknowledge |
| mem_req_o | output | 1 | Burst request, held until acknowledged |
| mem_we_o | output | 1 | 1 for a write burst, 0 for a read burst |
| mem_addr_o | output | EXT_AW | First word address of the burst |
| mem_ack_i | input | 1 | Burst accepted |
| mem_wdata_o | output | DATA_W | Write burst data |
| mem_wvalid_o | output | 1 | Write data word valid |
| mem_rdata_i | input | DATA_W | Read burst data |
| mem_rvalid_i | input | 1 | Read data word valid |

## Verification
The hardest situations to reach from the ports are the ones that overlap a running transfer. These are a control write and a buffer write that land while busy is high, and a combined command whose two transfers must run in a given order. The bench slows the memory side down with acknowledge latency and read-valid gaps, so that a transfer is still running when those writes arrive. It then reads the results back through the buffer and a model of external memory. A sweep over bases covers an unaligned base and a window that wraps past the top of the external address space.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREQ,
    ST_WDAT,
    ST_RREQ,
    ST_RDAT
  } cbm_state_e;

  // register indices (low address bits when the buffer select bit is 0)
  localparam logic [1:0] REG_BASE = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;

  // control and status bit positions
  localparam int CTL_REFRESH   = 0;
  localparam int CTL_FLUSH     = 1;
  localparam int STS_REFRESHED = 0;
  localparam int STS_FLUSHED   = 1;
  localparam int STS_BUSY      = 2;

endpackage

// File: rtl/cbm_buffer.sv
module cbm_buffer #(
  parameter int DATA_W = 32,
  parameter int BUF_AW = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [BUF_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BUF_AW-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [BUF_AW-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int WORDS = 1 << BUF_AW;

  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/cbm_engine.sv
module cbm_engine
  import cbm_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_AW    = 8,
  parameter int EXT_AW    = 30,
  parameter int BURST_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_flush,
  input  logic              go_refresh,
  input  logic [EXT_AW-1:0] base_i,
  output logic              busy,
  output logic              flush_done,
  output logic              refresh_done,
  output logic [BUF_AW-1:0] buf_raddr,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_waddr,
  output logic [DATA_W-1:0] buf_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [EXT_AW-1:0] mem_addr,
  input  logic              mem_ack,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rvalid
);
  // BURST_LEN must be a power of two, at least 2, and no larger than the buffer
  localparam int BL_W = $clog2(BURST_LEN);

  cbm_state_e        state_q, state_d;
  logic [BUF_AW-1:0] ptr_q, ptr_d;
  logic              pend_q, pend_d;
  logic [EXT_AW-1:0] base_q;
  logic              base_en;
  logic              burst_end;
  logic              buf_end;

  assign burst_end = &ptr_q[BL_W-1:0];
  assign buf_end   = &ptr_q;

  always_comb begin
    state_d      = state_q;
    ptr_d        = ptr_q;
    pend_d       = pend_q;
    base_en      = 1'b0;
    flush_done   = 1'b0;
    refresh_done = 1'b0;
    buf_we       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go_flush) begin
          state_d = ST_WREQ;
          pend_d  = go_refresh;
          ptr_d   = '0;
          base_en = 1'b1;
        end else if (go_refresh) begin
          state_d = ST_RREQ;
          ptr_d   = '0;
          base_en = 1'b1;
        end
      end
      ST_WREQ: if (mem_ack) state_d = ST_WDAT;
      ST_WDAT: begin
        ptr_d = ptr_q + 1'b1;
        if (burst_end) begin
          if (buf_end) begin
            flush_done = 1'b1;
            pend_d     = 1'b0;
            state_d    = pend_q ? ST_RREQ : ST_IDLE;
          end else begin
            state_d = ST_WREQ;
          end
        end
      end
      ST_RREQ: if (mem_ack) state_d = ST_RDAT;
      ST_RDAT: begin
        if (mem_rvalid) begin
          buf_we = 1'b1;
          ptr_d  = ptr_q + 1'b1;
          if (burst_end) begin
            if (buf_end) begin
              refresh_done = 1'b1;
              state_d      = ST_IDLE;
            end else begin
              state_d = ST_RREQ;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      pend_q  <= 1'b0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      pend_q  <= pend_d;
      if (base_en) base_q <= base_i;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign mem_req    = (state_q == ST_WREQ) || (state_q == ST_RREQ);
  assign mem_we     = (state_q == ST_WREQ);
  assign mem_addr   = base_q + {{(EXT_AW-BUF_AW){1'b0}}, ptr_q};
  assign mem_wvalid = (state_q == ST_WDAT);
  assign mem_wdata  = buf_rdata;
  assign buf_raddr  = ptr_q;
  assign buf_waddr  = ptr_q;
  assign buf_wdata  = mem_rdata;

endmodule

// File: rtl/cbm_regs.sv
module cbm_regs
  import cbm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BUF_AW = 8,
  parameter int EXT_AW = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_cyc,
  input  logic              wb_stb,
  input  logic              wb_we,
  input  logic [BUF_AW:0]   wb_adr,
  input  logic [DATA_W-1:0] wb_wdat,
  output logic [DATA_W-1:0] wb_rdat,
  output logic              wb_ack,
  input  logic              busy,
  input  logic              flush_done,
  input  logic              refresh_done,
  output logic [BUF_AW-1:0] host_addr,
  input  logic [DATA_W-1:0] host_rdata,
  output logic              host_we,
  output logic [DATA_W-1:0] host_wdata,
  output logic [EXT_AW-1:0] base,
  output logic              go_flush,
  output logic              go_refresh
);
  logic              req, wr, rd, sel_buf, ctrl_wr, base_en;
  logic [1:0]        reg_idx;
  logic              ack_q;
  logic [DATA_W-1:0] rdat_q, rd_mux;
  logic [EXT_AW-1:0] base_q;
  logic              flushed_q, flushed_d, refreshed_q, refreshed_d;

  assign req     = wb_cyc & wb_stb & ~ack_q;
  assign wr      = req & wb_we;
  assign rd      = req & ~wb_we;
  assign sel_buf = wb_adr[BUF_AW];
  assign reg_idx = wb_adr[1:0];

  assign ctrl_wr    = wr & ~sel_buf & (reg_idx == REG_CTRL) & ~busy;
  assign go_flush   = ctrl_wr & wb_wdat[CTL_FLUSH];
  assign go_refresh = ctrl_wr & wb_wdat[CTL_REFRESH];
  assign base_en    = wr & ~sel_buf & (reg_idx == REG_BASE);

  assign host_addr  = wb_adr[BUF_AW-1:0];
  assign host_we    = wr & sel_buf & ~busy;
  assign host_wdata = wb_wdat;

  always_comb begin
    flushed_d   = go_flush   ? 1'b0 : (flush_done   ? 1'b1 : flushed_q);
    refreshed_d = go_refresh ? 1'b0 : (refresh_done ? 1'b1 : refreshed_q);
  end

  always_comb begin
    rd_mux = '0;
    if (sel_buf) begin
      rd_mux = host_rdata;
    end else if (reg_idx == REG_BASE) begin
      rd_mux[EXT_AW-1:0] = base_q;
    end else if (reg_idx == REG_STAT) begin
      rd_mux[STS_REFRESHED] = refreshed_q;
      rd_mux[STS_FLUSHED]   = flushed_q;
      rd_mux[STS_BUSY]      = busy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q       <= 1'b0;
      rdat_q      <= '0;
      base_q      <= '0;
      flushed_q   <= 1'b0;
      refreshed_q <= 1'b0;
    end else begin
      ack_q       <= req;
      flushed_q   <= flushed_d;
      refreshed_q <= refreshed_d;
      if (rd)      rdat_q <= rd_mux;
      if (base_en) base_q <= wb_wdat[EXT_AW-1:0];
    end
  end

  assign wb_ack  = ack_q;
  assign wb_rdat = rdat_q;
  assign base    = base_q;

endmodule

// File: rtl/cache_block_mover.sv
module cache_block_mover #(
  parameter int DATA_W    = 32,
  parameter int BUF_AW    = 8,
  parameter int EXT_AW    = 30,
  parameter int BURST_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [BUF_AW:0]   wb_adr_i,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic              wb_ack_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [EXT_AW-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_wvalid_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_rvalid_i
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic              eng_busy, flush_done, refresh_done, go_flush, go_refresh;
  logic [EXT_AW-1:0] base_addr;
  logic [BUF_AW-1:0] e_raddr, e_waddr, h_addr;
  logic [DATA_W-1:0] e_rdata, e_wdata, h_rdata, h_wdata;
  logic              e_we, h_we;
  logic              b_we;
  logic [BUF_AW-1:0] b_waddr;
  logic [DATA_W-1:0] b_wdata;

  cbm_regs #(.DATA_W(DATA_W), .BUF_AW(BUF_AW), .EXT_AW(EXT_AW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .wb_cyc       (wb_cyc_i),
    .wb_stb       (wb_stb_i),
    .wb_we        (wb_we_i),
    .wb_adr       (wb_adr_i),
    .wb_wdat      (wb_dat_i),
    .wb_rdat      (wb_dat_o),
    .wb_ack       (wb_ack_o),
    .busy         (eng_busy),
    .flush_done   (flush_done),
    .refresh_done (refresh_done),
    .host_addr    (h_addr),
    .host_rdata   (h_rdata),
    .host_we      (h_we),
    .host_wdata   (h_wdata),
    .base         (base_addr),
    .go_flush     (go_flush),
    .go_refresh   (go_refresh)
  );

  cbm_engine #(.DATA_W(DATA_W), .BUF_AW(BUF_AW), .EXT_AW(EXT_AW), .BURST_LEN(BURST_LEN)) u_engine (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .go_flush     (go_flush),
    .go_refresh   (go_refresh),
    .base_i       (base_addr),
    .busy         (eng_busy),
    .flush_done   (flush_done),
    .refresh_done (refresh_done),
    .buf_raddr    (e_raddr),
    .buf_rdata    (e_rdata),
    .buf_we       (e_we),
    .buf_waddr    (e_waddr),
    .buf_wdata    (e_wdata),
    .mem_req      (mem_req_o),
    .mem_we       (mem_we_o),
    .mem_addr     (mem_addr_o),
    .mem_ack      (mem_ack_i),
    .mem_wdata    (mem_wdata_o),
    .mem_wvalid   (mem_wvalid_o),
    .mem_rdata    (mem_rdata_i),
    .mem_rvalid   (mem_rvalid_i)
  );

  // host writes only reach the buffer while idle, engine writes only while busy
  assign b_we    = e_we | h_we;
  assign b_waddr = e_we ? e_waddr : h_addr;
  assign b_wdata = e_we ? e_wdata : h_wdata;

  cbm_buffer #(.DATA_W(DATA_W), .BUF_AW(BUF_AW)) u_buffer (
    .clk     (clk),
    .we      (b_we),
    .waddr   (b_waddr),
    .wdata   (b_wdata),
    .raddr_a (e_raddr),
    .rdata_a (e_rdata),
    .raddr_b (h_addr),
    .rdata_b (h_rdata)
  );

endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
  parameter int EXT_AW    = 30,
  parameter int BURST_LEN = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wb_cyc,
  input logic              wb_stb,
  input logic              wb_ack,
  input logic              mem_req,
  input logic              mem_we,
  input logic [EXT_AW-1:0] mem_addr,
  input logic              mem_ack,
  input logic              mem_wvalid,
  input logic              busy
);
  localparam int CW = $clog2(BURST_LEN) + 2;

  logic [CW-1:0] wcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
    end else if (mem_req && mem_ack && mem_we) begin
      wcnt_q <= '0;
    end else if (mem_wvalid) begin
      wcnt_q <= wcnt_q + 1'b1;
    end
  end

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !mem_wvalid);

  a_r11_wvalid_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> !mem_req);

  a_r11_burst_words: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> wcnt_q < CW'(BURST_LEN));

  a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack |=> !wb_ack);

  a_r2_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_ack) |-> $past(wb_cyc && wb_stb));

endmodule

bind cache_block_mover cbm_checker #(.EXT_AW(EXT_AW), .BURST_LEN(BURST_LEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wb_cyc     (wb_cyc_i),
  .wb_stb     (wb_stb_i),
  .wb_ack     (wb_ack_o),
  .mem_req    (mem_req_o),
  .mem_we     (mem_we_o),
  .mem_addr   (mem_addr_o),
  .mem_ack    (mem_ack_i),
  .mem_wvalid (mem_wvalid_o),
  .busy       (eng_busy)
);

// File: tb/cache_block_mover_tb.sv
module cache_block_mover_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 32;
  localparam int BAW = 4;
  localparam int BL  = 4;
  localparam int EAW = 10;
  localparam int NW  = 1 << BAW;
  localparam int EXT_SZ = 1 << EAW;

  logic clk = 1'b0;
  logic rst_n;
  logic wb_cyc, wb_stb, wb_we;
  logic [BAW:0] wb_adr;
  logic [DW-1:0] wb_wdat, wb_rdat;
  logic wb_ack;
  logic mem_req, mem_we, mem_ack, mem_wvalid, mem_rvalid;
  logic [EAW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_block_mover #(.DATA_W(DW), .BUF_AW(BAW), .EXT_AW(EAW), .BURST_LEN(BL)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wb_cyc_i(wb_cyc), .wb_stb_i(wb_stb), .wb_we_i(wb_we), .wb_adr_i(wb_adr),
    .wb_dat_i(wb_wdat), .wb_dat_o(wb_rdat), .wb_ack_o(wb_ack),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_wdata_o(mem_wdata), .mem_wvalid_o(mem_wvalid),
    .mem_rdata_i(mem_rdata), .mem_rvalid_i(mem_rvalid)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [DW-1:0] ext [EXT_SZ];
  int lat = 0;
  bit gap = 0;
  bit gtog = 0;
  int wait_cnt, waddr, wleft, raddr, rleft;
  int nreq = 0;
  int req_addr [64];
  bit req_we [64];
  int proto_err = 0;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // external memory model, updated between clock edges
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
      wait_cnt = 0; wleft = 0; rleft = 0;
    end else begin
      if (mem_wvalid) begin
        if (wleft == 0) proto_err++;
        else begin
          ext[waddr] = mem_wdata;
          waddr = (waddr + 1) % EXT_SZ;
          wleft--;
        end
      end
      if (mem_rvalid) begin
        raddr = (raddr + 1) % EXT_SZ;
        rleft--;
      end
      mem_rvalid = 1'b0;
      if (rleft > 0) begin
        gtog = !gtog;
        if (!gap || gtog) begin
          mem_rvalid = 1'b1;
          mem_rdata = ext[raddr];
        end
      end
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wait_cnt >= lat) begin
          mem_ack = 1'b1;
          wait_cnt = 0;
          if (nreq < 64) begin
            req_addr[nreq] = int'(mem_addr);
            req_we[nreq] = mem_we;
          end
          nreq++;
          if (mem_we) begin waddr = int'(mem_addr); wleft = BL; end
          else begin raddr = int'(mem_addr); rleft = BL; end
        end else wait_cnt++;
      end
    end
  end

  task automatic wb_wr(input logic [BAW:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = a; wb_wdat = d;
    @(negedge clk);
    check(wb_ack === 1'b1, "R2 write ack", {31'd0, wb_ack}, 1);
    wb_cyc = 0; wb_stb = 0; wb_we = 0;
  endtask

  task automatic wb_rd(input logic [BAW:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_adr = a;
    @(negedge clk);
    check(wb_ack === 1'b1, "R2 read ack", {31'd0, wb_ack}, 1);
    d = wb_rdat;
    wb_cyc = 0; wb_stb = 0;
  endtask

  function automatic logic [BAW:0] badr(input int i);
    return {1'b1, BAW'(i)};
  endfunction

  function automatic logic [DW-1:0] pat(input int seed, input int i);
    return (32'h5A00_0000 ^ (DW'(seed) << 12)) + DW'(i) * 32'h0101_0013;
  endfunction

  // poll status until idle; flag bit must be 0 while busy and 1 when busy drops
  task automatic wait_done(input int fbit, input string tag);
    logic [DW-1:0] s;
    bit first = 1;
    for (int g = 0; g < 2000; g++) begin
      wb_rd(5'd2, s);
      if (first) check(s[2] === 1'b1, {tag, " busy after accept"}, s, 32'h4);
      first = 0;
      if (s[2]) check(s[fbit] === 1'b0, {tag, " flag low while busy"}, s, 0);
      else begin
        check(s[fbit] === 1'b1, {tag, " flag set when idle"}, s, 32'd1 << fbit);
        break;
      end
    end
  endtask

  task automatic run();
    logic [DW-1:0] d;
    logic [DW-1:0] p [NW];
    int bases [4] = '{0, 5, 512, 1016};
    wb_cyc = 0; wb_stb = 0; wb_we = 0; wb_adr = '0; wb_wdat = '0;
    for (int i = 0; i < EXT_SZ; i++) ext[i] = 32'hEEEE_0000 + DW'(i);
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(mem_req === 1'b0, "R1 no request", {31'd0, mem_req}, 0);
    check(mem_wvalid === 1'b0, "R1 no wvalid", {31'd0, mem_wvalid}, 0);
    wb_rd(5'd2, d); check(d === 0, "R1 status", d, 0);
    wb_rd(5'd0, d); check(d === 0, "R1 base", d, 0);

    // R2 registers
    wb_wr(5'd0, 32'h2AB); wb_rd(5'd0, d); check(d === 32'h2AB, "R2 base readback", d, 32'h2AB);
    wb_wr(5'd0, 32'hFFFF_FFFF); wb_rd(5'd0, d); check(d === 32'h3FF, "R2 base width", d, 32'h3FF);
    wb_wr(5'd1, 32'h0); wb_rd(5'd1, d); check(d === 0, "R2 control reads zero", d, 0);
    wb_rd(5'd2, d); check(d === 0, "R9 empty command no effect", d, 0);

    // R3 host buffer access
    for (int i = 0; i < NW; i++) wb_wr(badr(i), pat(1, i));
    for (int i = 0; i < NW; i++) begin
      wb_rd(badr(i), d); check(d === pat(1, i), "R3 buffer readback", d, pat(1, i));
    end

    // R4 R5 R6 R7 sweep over bases and memory timing
    for (int b = 0; b < 4; b++) begin
      for (int l = 0; l < 3; l++) begin
        int base = bases[b];
        int sd = b * 4 + l + 2;
        lat = l; gap = (l != 0);
        for (int i = 0; i < NW; i++) wb_wr(badr(i), pat(sd, i));
        ext[(base + EXT_SZ - 1) % EXT_SZ] = 32'hCAFE_0001;
        ext[(base + NW) % EXT_SZ] = 32'hCAFE_0002;
        wb_wr(5'd0, DW'(base));
        nreq = 0;
        wb_wr(5'd1, 32'h2);
        wait_done(1, "R6 flush");
        for (int i = 0; i < NW; i++)
          check(ext[(base + i) % EXT_SZ] === pat(sd, i), "R4 flushed word", ext[(base + i) % EXT_SZ], pat(sd, i));
        check(ext[(base + EXT_SZ - 1) % EXT_SZ] === 32'hCAFE_0001, "R4 below window untouched",
              ext[(base + EXT_SZ - 1) % EXT_SZ], 32'hCAFE_0001);
        check(ext[(base + NW) % EXT_SZ] === 32'hCAFE_0002, "R4 above window untouched",
              ext[(base + NW) % EXT_SZ], 32'hCAFE_0002);
        check(nreq == NW / BL, "R4 burst count", DW'(nreq), DW'(NW / BL));
        for (int k = 0; k < NW / BL; k++) begin
          check(req_addr[k] == (base + k * BL) % EXT_SZ && req_we[k], "R4 burst address",
                DW'(req_addr[k]), DW'((base + k * BL) % EXT_SZ));
        end
        for (int i = 0; i < NW; i++) ext[(base + i) % EXT_SZ] = pat(sd + 100, i);
        for (int i = 0; i < NW; i++) wb_wr(badr(i), 32'h0BAD_0000);
        nreq = 0;
        wb_wr(5'd1, 32'h1);
        wait_done(0, "R7 refresh");
        for (int i = 0; i < NW; i++) begin
          wb_rd(badr(i), d); check(d === pat(sd + 100, i), "R5 refreshed word", d, pat(sd + 100, i));
        end
        for (int k = 0; k < NW / BL; k++) begin
          check(req_addr[k] == (base + k * BL) % EXT_SZ && !req_we[k], "R5 burst address",
                DW'(req_addr[k]), DW'((base + k * BL) % EXT_SZ));
        end
      end
    end

    // R8 both commands at once
    lat = 1; gap = 1;
    for (int i = 0; i < NW; i++) begin p[i] = pat(77, i); wb_wr(badr(i), p[i]); end
    for (int i = 0; i < NW; i++) ext[100 + i] = pat(88, i);
    wb_wr(5'd0, 32'd100);
    nreq = 0;
    wb_wr(5'd1, 32'h3);
    wait_done(0, "R8 combined");
    wb_rd(5'd2, d); check(d === 32'h3, "R8 both flags set", d, 32'h3);
    check(nreq == 2 * NW / BL, "R8 burst count", DW'(nreq), DW'(2 * NW / BL));
    check(req_we[0] && !req_we[NW / BL], "R8 flush before refresh", {30'd0, req_we[0], req_we[NW / BL]}, 32'h2);
    for (int i = 0; i < NW; i++) begin
      check(ext[100 + i] === p[i], "R8 external holds buffer", ext[100 + i], p[i]);
      wb_rd(badr(i), d); check(d === p[i], "R8 buffer kept", d, p[i]);
    end

    // R9 R10 writes while busy
    lat = 3; gap = 0;
    for (int i = 0; i < NW; i++) begin p[i] = pat(55, i); wb_wr(badr(i), p[i]); end
    wb_wr(5'd0, 32'd300);
    nreq = 0;
    wb_wr(5'd1, 32'h2);
    wb_wr(5'd1, 32'h1);
    wb_wr(badr(3), 32'hDEAD_BEEF);
    wait_done(1, "R9 flush");
    repeat (20) @(negedge clk);
    check(nreq == NW / BL, "R9 ignored command adds no bursts", DW'(nreq), DW'(NW / BL));
    for (int k = 0; k < NW / BL; k++)
      check(req_we[k], "R9 no read burst", {31'd0, req_we[k]}, 1);
    wb_rd(5'd2, d); check(d === 32'h3, "R9 flags unchanged", d, 32'h3);
    wb_rd(badr(3), d); check(d === p[3], "R10 buffer write dropped", d, p[3]);
    check(ext[303] === p[3], "R10 flush wrote old value", ext[303], p[3]);

    check(proto_err == 0, "R11 write data outside burst", DW'(proto_err), 0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule